// File: doc/BRIEF.md
# Exception Priority and Fault Escalation Controller

This block sits in the trap path of a segmented protected-mode CPU core. Each cycle it looks at the pending exception and interrupt request lines and picks one event to service. For that event it produces the vector number, whether an error code is pushed, the error code itself, and whether the faulting instruction can be restarted. The result is registered and presented for a single cycle. Descriptor fetches, gate lookup and the stack pushes are done elsewhere. Those units consume the outputs of this block.

The controller also watches how protection faults nest inside one instruction. The instruction-boundary strobe marks where one instruction ends and the next begins. The first protection fault is serviced as-is. A second one before the next boundary is replaced by a double fault. A third one, raised while the double fault is being delivered, puts the core into a latched shutdown state that signals a halt cycle. From shutdown, an NMI can bring the core back, but only if no protection fault hits before the NMI handler reaches its first boundary. If a fault does hit, the core locks until reset. A protected-mode flag survives the NMI way out and is cleared by reset.

Top module: `exc_escalator`

## Requirements
- R1: While reset is low, and after its release with no request, the event-valid, halt and protected-mode outputs are 0.
- R2: Requests are ranked highest first: exception line, single step, NMI, coprocessor segment overrun, maskable interrupt, software INT. Exactly the highest-ranked pending request is serviced in a cycle.
- R3: The maskable interrupt request is ignored while its enable input is low. No event is produced for it, and a lower-ranked software INT is serviced instead.
- R4: Single step reports vector 1, NMI reports vector 2 and coprocessor segment overrun reports vector 9. The exception line, maskable interrupt and software INT report their own 8-bit vector inputs.
- R5: The error-code-valid output is 1 only for exception-line events with vector 8, 10, 11, 12 or 13, and for a double fault. It is 0 for every other event, including a software INT or maskable interrupt that carries one of those vectors.
- R6: The restartable output is 0 for vectors 8, 9 and 13 and 1 for every other serviced vector.
- R7: Error code layout: bit 0 = external flag, bit 1 = descriptor-table-of-interrupts flag, bits 15..2 = selector bits 15..2. When the no-selector input is 1, bits 15..2 are 0. Vector 8 always carries error code 0.
- R8: The second protection fault (exception line, vector 10..13) since the last boundary strobe is serviced as vector 8 with error code 0 and restartable 0.
- R9: A protection fault after a double fault and before the next boundary produces no event, and the halt output is 1 from the next cycle on.
- R10: In shutdown, every request other than NMI is ignored and the boundary strobe does not leave the state. An NMI arriving together with an exception-line request is the one serviced.
- R11: An NMI in shutdown is serviced as vector 2 and the halt output drops in that same cycle. A boundary strobe after that returns to normal operation. The protected-mode output, set by the protected-mode-set input, keeps its value.
- R12: A protection fault after such an NMI and before its boundary strobe produces no event and locks halt at 1. Later NMIs are then ignored, and only reset clears halt and protected mode.
- R13: The boundary strobe clears the nesting count. A protection fault in the same cycle as the strobe counts as the first fault of the new instruction.
- R14: Every output is registered. A request sampled at one clock edge shows at the outputs from that edge to the next, and event-valid is 0 in a cycle with nothing to service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| step_i | input | 1 | Instruction-boundary strobe |
| exc_req_i | input | 1 | Instruction exception request |
| exc_vec_i | input | VEC_W | Vector of the instruction exception |
| sstep_req_i | input | 1 | Single-step trap request |
| nmi_req_i | input | 1 | Non-maskable interrupt request |
| cso_req_i | input | 1 | Coprocessor segment overrun request |
| intr_req_i | input | 1 | Maskable interrupt request |
| intr_en_i | input | 1 | Maskable interrupt enable |
| intr_vec_i | input | VEC_W | Vector supplied with the maskable interrupt |
| swi_req_i | input | 1 | Software INT instruction request |
| swi_vec_i | input | VEC_W | Vector of the software INT |
| sel_i | input | SEL_W | Selector involved in the fault |
| sel_none_i | input | 1 | No selector is involved |
| sel_idt_i | input | 1 | Selector refers to the interrupt descriptor table |
| sel_ext_i | input | 1 | Event was external to the program |
| pm_set_i | input | 1 | Sets the protected-mode flag |
| ev_valid_o | output | 1 | An event is being serviced this cycle |
| vec_o | output | VEC_W | Vector of the serviced event |
| err_valid_o | output | 1 | An error code is pushed |
| err_code_o | output | SEL_W | Error code value |
| restart_o | output | 1 | Faulting instruction is restartable |
| halt_o | output | 1 | Shutdown: halt bus cycle indication |
| pmode_o | output | 1 | Protected-mode flag |

## Verification
Two things can land in the same clock edge: picking a request by rank, and the escalation state machine deciding to override that pick. One overlap is an NMI and an exception-line request asserted together while in shutdown. The ranking would pick the exception, but the state machine must let only the NMI through, so the bench expects vector 2 with halt dropping. The other overlap is a boundary strobe in the same cycle as a protection fault, both in normal running and while the NMI escape is pending. The bench judges it by the vector that follows: it must be the fault's own vector, not 8 and not a lock.

// File: rtl/exc_escalator_pkg.sv
package exc_escalator_pkg;

    // Rank of each request source; lower index wins.
    localparam int RANK_EXC   = 0;
    localparam int RANK_STEP  = 1;
    localparam int RANK_NMI   = 2;
    localparam int RANK_CSO   = 3;
    localparam int RANK_INTR  = 4;
    localparam int RANK_SWI   = 5;
    localparam int SRC_COUNT  = 6;

    // Fixed vector numbers.
    localparam int VEC_STEP   = 1;
    localparam int VEC_NMI    = 2;
    localparam int VEC_DBL    = 8;
    localparam int VEC_CSO    = 9;
    localparam int VEC_PROT_LO = 10;
    localparam int VEC_PROT_HI = 13;
    localparam int VEC_GP     = 13;

    typedef enum logic [1:0] {
        NS_RUN      = 2'd0,
        NS_SHUT     = 2'd1,
        NS_SHUT_NMI = 2'd2,
        NS_LOCK     = 2'd3
    } nest_e;

    function automatic logic is_prot_vec(input int unsigned v);
        return (v >= VEC_PROT_LO) && (v <= VEC_PROT_HI);
    endfunction

    function automatic logic is_fixed_abort_vec(input int unsigned v);
        return (v == VEC_DBL) || (v == VEC_CSO) || (v == VEC_GP);
    endfunction

endpackage

// File: rtl/exc_src_pick.sv
module exc_src_pick #(
    parameter int NSRC = 6
) (
    input  logic [NSRC-1:0] req_i,
    output logic [NSRC-1:0] grant_o,
    output logic            any_o
);
    logic found;

    always_comb begin
        grant_o = '0;
        found   = 1'b0;
        for (int i = 0; i < NSRC; i++) begin
            if (req_i[i] && !found) begin
                grant_o[i] = 1'b1;
                found      = 1'b1;
            end
        end
        any_o = found;
    end
endmodule

// File: rtl/exc_vec_attr.sv
module exc_vec_attr
    import exc_escalator_pkg::*;
#(
    parameter int VEC_W = 8,
    parameter int SEL_W = 16
) (
    input  logic [VEC_W-1:0] vec_i,
    input  logic             from_exc_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             sel_none_i,
    input  logic             idt_i,
    input  logic             ext_i,
    output logic             err_valid_o,
    output logic             restart_o,
    output logic [SEL_W-1:0] err_code_o
);
    localparam int IDX_W = SEL_W - 2;

    logic        is_dbl;
    logic [31:0] vec_wide;

    always_comb begin
        vec_wide    = 32'(vec_i);
        is_dbl      = (vec_wide == 32'(VEC_DBL));
        err_valid_o = from_exc_i && (is_dbl || is_prot_vec(vec_wide));
        restart_o   = !is_fixed_abort_vec(vec_wide);
        if (is_dbl) begin
            err_code_o = '0;
        end else if (sel_none_i) begin
            err_code_o = {{IDX_W{1'b0}}, idt_i, ext_i};
        end else begin
            err_code_o = {sel_i[SEL_W-1:2], idt_i, ext_i};
        end
    end
endmodule

// File: rtl/exc_nest_fsm.sv
module exc_nest_fsm
    import exc_escalator_pkg::*;
#(
    parameter int NEST_W = 2
) (
    input  nest_e             state_q_i,
    input  logic [NEST_W-1:0] nest_q_i,
    input  logic              step_i,
    input  logic              prot_i,
    input  logic              any_i,
    input  logic              nmi_i,
    output nest_e             state_d_o,
    output logic [NEST_W-1:0] nest_d_o,
    output logic              emit_pick_o,
    output logic              emit_dbl_o,
    output logic              emit_nmi_o
);
    localparam logic [NEST_W-1:0] LVL_CLEAR = NEST_W'(0);
    localparam logic [NEST_W-1:0] LVL_ONE   = NEST_W'(1);
    localparam logic [NEST_W-1:0] LVL_DBL   = NEST_W'(2);

    logic [NEST_W-1:0] base;
    logic              run_like;

    always_comb begin
        base        = step_i ? LVL_CLEAR : nest_q_i;
        run_like    = (state_q_i == NS_RUN) ||
                      ((state_q_i == NS_SHUT_NMI) && step_i);
        state_d_o   = state_q_i;
        nest_d_o    = base;
        emit_pick_o = 1'b0;
        emit_dbl_o  = 1'b0;
        emit_nmi_o  = 1'b0;

        if (run_like) begin
            state_d_o = NS_RUN;
            if (prot_i) begin
                if (base == LVL_CLEAR) begin
                    emit_pick_o = 1'b1;
                    nest_d_o    = LVL_ONE;
                end else if (base == LVL_ONE) begin
                    emit_dbl_o  = 1'b1;
                    nest_d_o    = LVL_DBL;
                end else begin
                    state_d_o   = NS_SHUT;
                    nest_d_o    = LVL_CLEAR;
                end
            end else begin
                emit_pick_o = any_i;
            end
        end else if (state_q_i == NS_SHUT) begin
            nest_d_o = LVL_CLEAR;
            if (nmi_i) begin
                emit_nmi_o = 1'b1;
                state_d_o  = NS_SHUT_NMI;
            end
        end else if (state_q_i == NS_SHUT_NMI) begin
            nest_d_o = LVL_CLEAR;
            if (prot_i) begin
                state_d_o = NS_LOCK;
            end else begin
                emit_pick_o = any_i;
            end
        end else begin
            nest_d_o = LVL_CLEAR;
        end
    end
endmodule

// File: rtl/exc_escalator.sv
module exc_escalator
    import exc_escalator_pkg::*;
#(
    parameter int VEC_W = 8,
    parameter int SEL_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    input  logic             exc_req_i,
    input  logic [VEC_W-1:0] exc_vec_i,
    input  logic             sstep_req_i,
    input  logic             nmi_req_i,
    input  logic             cso_req_i,
    input  logic             intr_req_i,
    input  logic             intr_en_i,
    input  logic [VEC_W-1:0] intr_vec_i,
    input  logic             swi_req_i,
    input  logic [VEC_W-1:0] swi_vec_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             sel_none_i,
    input  logic             sel_idt_i,
    input  logic             sel_ext_i,
    input  logic             pm_set_i,
    output logic             ev_valid_o,
    output logic [VEC_W-1:0] vec_o,
    output logic             err_valid_o,
    output logic [SEL_W-1:0] err_code_o,
    output logic             restart_o,
    output logic             halt_o,
    output logic             pmode_o
);
    localparam int NSRC   = SRC_COUNT;
    localparam int NEST_W = 2;

    typedef struct packed {
        nest_e             state;
        logic [NEST_W-1:0] nest;
        logic              pmode;
        logic              ev_valid;
        logic [VEC_W-1:0]  vec;
        logic              err_valid;
        logic [SEL_W-1:0]  err_code;
        logic              restart;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [NSRC-1:0]   req;
    logic [NSRC-1:0]   grant;
    logic              req_any;
    logic              prot_fault;
    logic [VEC_W-1:0]  pick_vec;
    logic [VEC_W-1:0]  out_vec;
    logic              out_from_exc;
    logic              attr_errv;
    logic              attr_restart;
    logic [SEL_W-1:0]  attr_code;
    nest_e             state_nx;
    logic [NEST_W-1:0] nest_nx;
    logic              emit_pick, emit_dbl, emit_nmi;

    always_comb begin
        req            = '0;
        req[RANK_EXC]  = exc_req_i;
        req[RANK_STEP] = sstep_req_i;
        req[RANK_NMI]  = nmi_req_i;
        req[RANK_CSO]  = cso_req_i;
        req[RANK_INTR] = intr_req_i && intr_en_i;
        req[RANK_SWI]  = swi_req_i;
    end

    assign prot_fault = exc_req_i && is_prot_vec(32'(exc_vec_i));

    exc_src_pick #(.NSRC(NSRC)) u_pick (
        .req_i   (req),
        .grant_o (grant),
        .any_o   (req_any)
    );

    exc_nest_fsm #(.NEST_W(NEST_W)) u_nest (
        .state_q_i   (ctl_q.state),
        .nest_q_i    (ctl_q.nest),
        .step_i      (step_i),
        .prot_i      (prot_fault),
        .any_i       (req_any),
        .nmi_i       (nmi_req_i),
        .state_d_o   (state_nx),
        .nest_d_o    (nest_nx),
        .emit_pick_o (emit_pick),
        .emit_dbl_o  (emit_dbl),
        .emit_nmi_o  (emit_nmi)
    );

    always_comb begin
        if (grant[RANK_EXC]) begin
            pick_vec = exc_vec_i;
        end else if (grant[RANK_STEP]) begin
            pick_vec = VEC_W'(VEC_STEP);
        end else if (grant[RANK_NMI]) begin
            pick_vec = VEC_W'(VEC_NMI);
        end else if (grant[RANK_CSO]) begin
            pick_vec = VEC_W'(VEC_CSO);
        end else if (grant[RANK_INTR]) begin
            pick_vec = intr_vec_i;
        end else if (grant[RANK_SWI]) begin
            pick_vec = swi_vec_i;
        end else begin
            pick_vec = '0;
        end
    end

    always_comb begin
        if (emit_dbl) begin
            out_vec = VEC_W'(VEC_DBL);
        end else if (emit_nmi) begin
            out_vec = VEC_W'(VEC_NMI);
        end else if (emit_pick) begin
            out_vec = pick_vec;
        end else begin
            out_vec = '0;
        end
        out_from_exc = emit_dbl || (emit_pick && grant[RANK_EXC]);
    end

    exc_vec_attr #(.VEC_W(VEC_W), .SEL_W(SEL_W)) u_attr (
        .vec_i       (out_vec),
        .from_exc_i  (out_from_exc),
        .sel_i       (sel_i),
        .sel_none_i  (sel_none_i),
        .idt_i       (sel_idt_i),
        .ext_i       (sel_ext_i),
        .err_valid_o (attr_errv),
        .restart_o   (attr_restart),
        .err_code_o  (attr_code)
    );

    always_comb begin
        ctl_d           = ctl_q;
        ctl_d.state     = state_nx;
        ctl_d.nest      = nest_nx;
        ctl_d.pmode     = ctl_q.pmode || pm_set_i;
        ctl_d.ev_valid  = emit_pick || emit_dbl || emit_nmi;
        ctl_d.vec       = out_vec;
        ctl_d.err_valid = ctl_d.ev_valid && attr_errv;
        ctl_d.err_code  = ctl_d.err_valid ? attr_code : '0;
        ctl_d.restart   = ctl_d.ev_valid && attr_restart;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{state: NS_RUN, default: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign ev_valid_o  = ctl_q.ev_valid;
    assign vec_o       = ctl_q.vec;
    assign err_valid_o = ctl_q.err_valid;
    assign err_code_o  = ctl_q.err_code;
    assign restart_o   = ctl_q.restart;
    assign halt_o      = (ctl_q.state == NS_SHUT) || (ctl_q.state == NS_LOCK);
    assign pmode_o     = ctl_q.pmode;
endmodule

// File: rtl/exc_escalator_chk.sv
module exc_escalator_chk #(
    parameter int VEC_W = 8,
    parameter int SEL_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ev_valid_o,
    input logic [VEC_W-1:0] vec_o,
    input logic             err_valid_o,
    input logic [SEL_W-1:0] err_code_o,
    input logic             restart_o,
    input logic             halt_o,
    input logic             pmode_o
);
    // R5: an error code only accompanies a serviced event with a coded vector
    p_errv_vec_r5: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid_o |-> (ev_valid_o &&
            ((vec_o == VEC_W'(8)) || ((vec_o >= VEC_W'(10)) && (vec_o <= VEC_W'(13))))));

    // R8: the double fault always pushes a zero error code
    p_dbl_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid_o && err_valid_o && (vec_o == VEC_W'(8))) |-> (err_code_o == '0));

    // R6: vectors 8, 9 and 13 are never flagged restartable
    p_abort_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid_o && ((vec_o == VEC_W'(8)) || (vec_o == VEC_W'(9)) || (vec_o == VEC_W'(13))))
            |-> !restart_o);

    // R10: nothing is serviced while the halt indication is up
    p_halt_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        halt_o |-> !ev_valid_o);

    // R11: only reset clears protected mode
    p_pmode_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(pmode_o));
endmodule

bind exc_escalator exc_escalator_chk #(.VEC_W(VEC_W), .SEL_W(SEL_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ev_valid_o  (ev_valid_o),
    .vec_o       (vec_o),
    .err_valid_o (err_valid_o),
    .err_code_o  (err_code_o),
    .restart_o   (restart_o),
    .halt_o      (halt_o),
    .pmode_o     (pmode_o)
);

// File: tb/exc_escalator_bench.sv
`timescale 1ns/1ps
module exc_escalator_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step_i, exc_req_i, sstep_req_i, nmi_req_i, cso_req_i;
    logic        intr_req_i, intr_en_i, swi_req_i;
    logic [7:0]  exc_vec_i, intr_vec_i, swi_vec_i;
    logic [15:0] sel_i;
    logic        sel_none_i, sel_idt_i, sel_ext_i, pm_set_i;
    logic        ev_valid_o, err_valid_o, restart_o, halt_o, pmode_o;
    logic [7:0]  vec_o;
    logic [15:0] err_code_o;

    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    exc_escalator u_exc_escalator (
        .clk(clk), .rst_n(rst_n), .step_i(step_i),
        .exc_req_i(exc_req_i), .exc_vec_i(exc_vec_i),
        .sstep_req_i(sstep_req_i), .nmi_req_i(nmi_req_i), .cso_req_i(cso_req_i),
        .intr_req_i(intr_req_i), .intr_en_i(intr_en_i), .intr_vec_i(intr_vec_i),
        .swi_req_i(swi_req_i), .swi_vec_i(swi_vec_i),
        .sel_i(sel_i), .sel_none_i(sel_none_i), .sel_idt_i(sel_idt_i),
        .sel_ext_i(sel_ext_i), .pm_set_i(pm_set_i),
        .ev_valid_o(ev_valid_o), .vec_o(vec_o), .err_valid_o(err_valid_o),
        .err_code_o(err_code_o), .restart_o(restart_o), .halt_o(halt_o),
        .pmode_o(pmode_o)
    );

    // req bits: [0] exception, [1] single step, [2] NMI, [3] seg overrun, [4] INTR, [5] INT
    typedef struct packed {
        logic [5:0]  req;
        logic        en;
        logic [7:0]  ev;
        logic [7:0]  iv;
        logic [7:0]  sv;
        logic [15:0] sel;
        logic        none;
        logic        idt;
        logic        ext;
        logic        x_ev;
        logic [7:0]  x_vec;
        logic        x_errv;
        logic [15:0] x_err;
        logic        x_rst;
    } row_t;

    localparam int NROWS = 16;
    localparam row_t TBL [NROWS] = '{
        '{6'b000001, 1'b0, 8'd0,  8'h00, 8'h00, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b1, 8'd0,  1'b0, 16'h0000, 1'b1},
        '{6'b000001, 1'b0, 8'd13, 8'h00, 8'h00, 16'h1234, 1'b0, 1'b0, 1'b1, 1'b1, 8'd13, 1'b1, 16'h1235, 1'b0},
        '{6'b000001, 1'b0, 8'd11, 8'h00, 8'h00, 16'hABCF, 1'b0, 1'b1, 1'b0, 1'b1, 8'd11, 1'b1, 16'hABCE, 1'b1},
        '{6'b000001, 1'b0, 8'd12, 8'h00, 8'h00, 16'hFFFF, 1'b1, 1'b0, 1'b1, 1'b1, 8'd12, 1'b1, 16'h0001, 1'b1},
        '{6'b000001, 1'b0, 8'd10, 8'h00, 8'h00, 16'h0048, 1'b0, 1'b0, 1'b0, 1'b1, 8'd10, 1'b1, 16'h0048, 1'b1},
        '{6'b111111, 1'b1, 8'd6,  8'h20, 8'h80, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b1, 8'd6,  1'b0, 16'h0000, 1'b1},
        '{6'b111110, 1'b1, 8'd0,  8'h20, 8'h80, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b1, 8'd1,  1'b0, 16'h0000, 1'b1},
        '{6'b111100, 1'b1, 8'd0,  8'h20, 8'h80, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b1, 8'd2,  1'b0, 16'h0000, 1'b1},
        '{6'b111000, 1'b1, 8'd0,  8'h20, 8'h80, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b1, 8'd9,  1'b0, 16'h0000, 1'b0},
        '{6'b110000, 1'b1, 8'd0,  8'h20, 8'h80, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b1, 8'h20, 1'b0, 16'h0000, 1'b1},
        '{6'b110000, 1'b0, 8'd0,  8'h20, 8'h80, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b1, 8'h80, 1'b0, 16'h0000, 1'b1},
        '{6'b010000, 1'b0, 8'd0,  8'h20, 8'h80, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 8'd0,  1'b0, 16'h0000, 1'b0},
        '{6'b000001, 1'b0, 8'd8,  8'h00, 8'h00, 16'h1234, 1'b0, 1'b0, 1'b1, 1'b1, 8'd8,  1'b1, 16'h0000, 1'b0},
        '{6'b000001, 1'b0, 8'd7,  8'h00, 8'h00, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b1, 8'd7,  1'b0, 16'h0000, 1'b1},
        '{6'b000000, 1'b0, 8'd0,  8'h00, 8'h00, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 8'd0,  1'b0, 16'h0000, 1'b0},
        '{6'b100000, 1'b0, 8'd0,  8'h00, 8'd13, 16'h1234, 1'b0, 1'b0, 1'b1, 1'b1, 8'd13, 1'b0, 16'h0000, 1'b0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clear_in();
        step_i = 1'b0; exc_req_i = 1'b0; sstep_req_i = 1'b0; nmi_req_i = 1'b0;
        cso_req_i = 1'b0; intr_req_i = 1'b0; intr_en_i = 1'b0; swi_req_i = 1'b0;
        exc_vec_i = 8'h00; intr_vec_i = 8'h00; swi_vec_i = 8'h00; sel_i = 16'h0000;
        sel_none_i = 1'b0; sel_idt_i = 1'b0; sel_ext_i = 1'b0; pm_set_i = 1'b0;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic fault(input logic [7:0] v, input logic strobe);
        clear_in();
        exc_req_i = 1'b1; exc_vec_i = v; step_i = strobe; sel_i = 16'h0030;
        tick();
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL R14 watchdog actual=running expected=finished");
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        clear_in();
        repeat (3) @(negedge clk);
        chk("R1 valid in reset", 32'(ev_valid_o), 32'd0);
        chk("R1 halt in reset", 32'(halt_o), 32'd0);
        chk("R1 pmode in reset", 32'(pmode_o), 32'd0);
        rst_n = 1'b1;
        tick();
        chk("R1 valid idle", 32'(ev_valid_o), 32'd0);
        chk("R1 halt idle", 32'(halt_o), 32'd0);
        chk("R1 pmode idle", 32'(pmode_o), 32'd0);

        pm_set_i = 1'b1;
        tick();
        clear_in();
        chk("R11 pmode set", 32'(pmode_o), 32'd1);

        // table walk; every row carries a boundary strobe so nesting starts clear
        for (int i = 0; i < NROWS; i++) begin
            clear_in();
            step_i      = 1'b1;
            exc_req_i   = TBL[i].req[0];
            sstep_req_i = TBL[i].req[1];
            nmi_req_i   = TBL[i].req[2];
            cso_req_i   = TBL[i].req[3];
            intr_req_i  = TBL[i].req[4];
            swi_req_i   = TBL[i].req[5];
            intr_en_i   = TBL[i].en;
            exc_vec_i   = TBL[i].ev;
            intr_vec_i  = TBL[i].iv;
            swi_vec_i   = TBL[i].sv;
            sel_i       = TBL[i].sel;
            sel_none_i  = TBL[i].none;
            sel_idt_i   = TBL[i].idt;
            sel_ext_i   = TBL[i].ext;
            tick();
            chk($sformatf("R2 R3 R14 row%0d valid", i), 32'(ev_valid_o), 32'(TBL[i].x_ev));
            if (TBL[i].x_ev) begin
                chk($sformatf("R2 R4 row%0d vector", i), 32'(vec_o), 32'(TBL[i].x_vec));
                chk($sformatf("R5 row%0d err flag", i), 32'(err_valid_o), 32'(TBL[i].x_errv));
                chk($sformatf("R6 row%0d restart", i), 32'(restart_o), 32'(TBL[i].x_rst));
                if (TBL[i].x_errv) begin
                    chk($sformatf("R7 row%0d err code", i), 32'(err_code_o), 32'(TBL[i].x_err));
                end
            end
        end

        // nesting: first fault, second becomes double fault, third shuts down
        fault(8'd13, 1'b1);
        chk("R13 first fault vector", 32'(vec_o), 32'd13);
        fault(8'd11, 1'b0);
        chk("R8 double fault valid", 32'(ev_valid_o), 32'd1);
        chk("R8 double fault vector", 32'(vec_o), 32'd8);
        chk("R8 double fault err flag", 32'(err_valid_o), 32'd1);
        chk("R8 double fault code", 32'(err_code_o), 32'd0);
        chk("R8 double fault restart", 32'(restart_o), 32'd0);
        fault(8'd12, 1'b0);
        chk("R9 no event on third fault", 32'(ev_valid_o), 32'd0);
        chk("R9 halt raised", 32'(halt_o), 32'd1);

        // shutdown ignores everything but NMI, even with a strobe
        clear_in();
        exc_req_i = 1'b1; exc_vec_i = 8'd0; sstep_req_i = 1'b1; intr_req_i = 1'b1;
        intr_en_i = 1'b1; swi_req_i = 1'b1; cso_req_i = 1'b1; step_i = 1'b1;
        tick();
        chk("R10 ignored in shutdown", 32'(ev_valid_o), 32'd0);
        chk("R10 halt held", 32'(halt_o), 32'd1);

        // NMI escape, with a simultaneous exception request
        clear_in();
        nmi_req_i = 1'b1; exc_req_i = 1'b1; exc_vec_i = 8'd0;
        tick();
        chk("R10 NMI wins in shutdown", 32'(vec_o), 32'd2);
        chk("R11 NMI valid", 32'(ev_valid_o), 32'd1);
        chk("R11 halt dropped", 32'(halt_o), 32'd0);
        clear_in();
        step_i = 1'b1;
        tick();
        chk("R14 no event after pulse", 32'(ev_valid_o), 32'd0);
        chk("R11 halt after exit", 32'(halt_o), 32'd0);
        chk("R11 pmode kept", 32'(pmode_o), 32'd1);

        // strobe clears nesting
        fault(8'd13, 1'b0);
        chk("R13 fault after exit", 32'(vec_o), 32'd13);
        fault(8'd11, 1'b1);
        chk("R13 strobe restarts count", 32'(vec_o), 32'd11);
        fault(8'd12, 1'b0);
        chk("R8 second fault again", 32'(vec_o), 32'd8);
        fault(8'd13, 1'b0);
        chk("R9 shutdown again", 32'(halt_o), 32'd1);

        // NMI escape with strobe and fault together: fault counts as new instruction
        clear_in();
        nmi_req_i = 1'b1;
        tick();
        chk("R11 second NMI escape", 32'(vec_o), 32'd2);
        fault(8'd10, 1'b1);
        chk("R13 fault with strobe after NMI", 32'(vec_o), 32'd10);
        chk("R13 no halt", 32'(halt_o), 32'd0);
        fault(8'd11, 1'b0);
        chk("R8 double in new instruction", 32'(vec_o), 32'd8);
        fault(8'd12, 1'b0);
        chk("R9 third shutdown", 32'(halt_o), 32'd1);

        // fault during NMI delivery locks
        clear_in();
        nmi_req_i = 1'b1;
        tick();
        chk("R11 NMI before lock", 32'(vec_o), 32'd2);
        fault(8'd13, 1'b0);
        chk("R12 no event on fault", 32'(ev_valid_o), 32'd0);
        chk("R12 halt locked", 32'(halt_o), 32'd1);
        clear_in();
        nmi_req_i = 1'b1;
        tick();
        chk("R12 NMI ignored when locked", 32'(ev_valid_o), 32'd0);
        chk("R12 halt stays", 32'(halt_o), 32'd1);
        clear_in();
        step_i = 1'b1;
        tick();
        chk("R12 strobe does not unlock", 32'(halt_o), 32'd1);

        clear_in();
        rst_n = 1'b0;
        @(negedge clk);
        chk("R12 reset clears halt", 32'(halt_o), 32'd0);
        chk("R12 reset clears pmode", 32'(pmode_o), 32'd0);
        rst_n = 1'b1;
        tick();

        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule